// File: doc/BRIEF.md
# Interrupt Controller CPU Interface

This block is the per-processor front end of an interrupt controller. Each cycle it scans a set of interrupt state vectors (enable, pending, active, group, CPU target, and an 8-bit priority per interrupt). From these it picks the most urgent interrupt that this processor may take. It shows that interrupt's ID and priority, and raises a request line when the interrupt is urgent enough to pre-empt the work that is running.

Urgency is judged on group priority. Group priority is the 8-bit priority with its low bits cleared, and the number of bits cleared comes from a binary-point setting. The block keeps two binary-point copies:

- a secure copy;
- a non-secure alias copy.

Both are reached through a small register port that carries a security attribute. How each copy can be seen and written depends on a common-binary-point control bit.

The block also holds the running priority:

- acknowledge logic loads it when an interrupt is taken;
- end-of-interrupt logic drops it back to idle;
- it reads back through the same register port.

Top module: `irq_cpu_if`

## Requirements
- R1: An interrupt is a candidate only when it is enabled, pending and not active, and either its ID is below `NUM_PRIV` (private to this CPU) or bit `CPU_IDX` of its target field is set.
- R2: Among candidates the lowest priority value wins, and on equal priority the lowest ID wins. `best_id` and `best_prio` give the winner.
- R3: With no candidate, `best_id` is 1023 and `best_prio` is 0xFF.
- R4: Group priority is the priority with its low (bp+1) bits cleared. For a group-1 winner (`irq_grp` bit = 1) with `ctl_cbp` = 0, bp is the non-secure copy minus one. In every other case bp is the secure copy.
- R5: `irq_req` is 1 exactly when `ctl_en` = 1, a candidate exists, and its group priority is strictly below the running priority. The running priority is a 9-bit value, and idle is 256.
- R6: The running priority resets to idle. When `rp_load` = 1 it takes `rp_val` at the next edge. Otherwise, when `rp_drop` = 1, it returns to idle. If both are set, `rp_load` wins.
- R7: With `reg_sel` = 1 the port reads the running priority. An idle value reads as 0xFF, except when `LEGACY_REV` = 1, where the low 8 bits are returned.
- R8: With `reg_sel` = 0 and `reg_ns` = 1, a read returns min(secure copy + 1, 7) when `ctl_cbp` = 1, and the non-secure copy when `ctl_cbp` = 0.
- R9: A non-secure binary-point write (`reg_wr` = 1, `reg_sel` = 0, `reg_ns` = 1) has no effect when `ctl_cbp` = 1. Otherwise it stores `reg_wdata[2:0]`, raised to at least `MIN_BP_NS` (default 1). The non-secure copy resets to `MIN_BP_NS`.
- R10: Secure binary-point accesses (`reg_ns` = 0) read the secure copy and write `reg_wdata[2:0]` to it, raised to at least `MIN_BP_S` (default 0). The secure copy resets to `MIN_BP_S`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_en | input | NUM_IRQ | Per-interrupt enable |
| irq_pend | input | NUM_IRQ | Per-interrupt pending |
| irq_act | input | NUM_IRQ | Per-interrupt active |
| irq_grp | input | NUM_IRQ | Per-interrupt group (1 = group 1) |
| irq_tgt | input | NUM_IRQ*NCPU | CPU target fields, NCPU bits per interrupt |
| irq_prio | input | NUM_IRQ*8 | Priorities, 8 bits per interrupt |
| ctl_en | input | 1 | CPU interface signalling enable |
| ctl_cbp | input | 1 | Common binary point control |
| rp_load | input | 1 | Load running priority |
| rp_val | input | 8 | Value for rp_load |
| rp_drop | input | 1 | Return running priority to idle |
| reg_sel | input | 1 | 0 = binary point, 1 = running priority |
| reg_wr | input | 1 | Register write strobe |
| reg_ns | input | 1 | 1 = non-secure access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current selection |
| best_id | output | 10 | Winning interrupt ID, 1023 when none |
| best_prio | output | 8 | Winning priority, 0xFF when none |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with 16 interrupts, 4 of them private, and a 4-bit target field with this CPU at index 1. This keeps private and shared interrupts, untargeted shared ones, and ties between IDs within a short random run. The groups and the default clamp minimums are left on. As a result, the group-1 "alias minus one" path, the non-secure floor of 1, and the saturation at 7 of the common view are all reached. The idle running priority of 256 can be compared against the 0xFF group priority of a lowest-urgency interrupt.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;
  localparam logic [8:0] IDLE_PRIO = 9'h100;

  // clear the low (bp+1) bits of a priority
  function automatic logic [7:0] grp_prio(input logic [7:0] p, input logic [2:0] bp);
    logic [8:0] m;
    m = 9'h1FF << ({1'b0, bp} + 4'd1);
    return p & m[7:0];
  endfunction

  // non-secure view of the secure copy under common binary point
  function automatic logic [2:0] ns_common_view(input logic [2:0] s);
    return (s == 3'd7) ? 3'd7 : s + 3'd1;
  endfunction

  function automatic logic [2:0] clamp_min(input logic [2:0] v, input logic [2:0] lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/cif_select.sv
module cif_select
  import cif_pkg::*;
#(
  parameter int NUM_IRQ  = 32,
  parameter int NUM_PRIV = 8,
  parameter int NCPU     = 8,
  parameter int CPU_IDX  = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IRQ-1:0]      irq_en,
  input  logic [NUM_IRQ-1:0]      irq_pend,
  input  logic [NUM_IRQ-1:0]      irq_act,
  input  logic [NUM_IRQ-1:0]      irq_grp,
  input  logic [NUM_IRQ*NCPU-1:0] irq_tgt,
  input  logic [NUM_IRQ*8-1:0]    irq_prio,
  output logic [ID_W-1:0]         best_id,
  output logic [7:0]              best_prio,
  output logic                    best_grp
);
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] cand;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cand
    if (i < NUM_PRIV) begin : g_priv
      assign cand[i] = irq_en[i] & irq_pend[i] & ~irq_act[i];
    end else begin : g_shared
      assign cand[i] = irq_en[i] & irq_pend[i] & ~irq_act[i] & irq_tgt[i*NCPU+CPU_IDX];
    end
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    best_id   = NO_IRQ;
    best_prio = 8'hFF;
    best_grp  = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!found || irq_prio[i*8 +: 8] < best_prio)) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = irq_prio[i*8 +: 8];
        best_grp  = irq_grp[i];
      end
    end
  end

  logic [IW-1:0] best_idx;
  assign best_idx = best_id[IW-1:0];

  assert_pick_is_candidate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (best_id != NO_IRQ) |-> (irq_en[best_idx] && irq_pend[best_idx] && !irq_act[best_idx]));

  assert_none_reports_1023_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> (best_id == NO_IRQ && best_prio == 8'hFF));
endmodule

// File: rtl/cif_bpr.sv
module cif_bpr
  import cif_pkg::*;
#(
  parameter int MIN_BP_S  = 0,
  parameter int MIN_BP_NS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       acc_ns,
  input  logic [2:0] wr_data,
  input  logic       cbp,
  output logic [2:0] bp_s,
  output logic [2:0] bp_ns,
  output logic [2:0] rd_val
);
  localparam logic [2:0] LO_S  = 3'(MIN_BP_S);
  localparam logic [2:0] LO_NS = 3'(MIN_BP_NS);

  logic ns_write_ignored;
  assign ns_write_ignored = wr_en & acc_ns & cbp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_s  <= LO_S;
      bp_ns <= LO_NS;
    end else if (wr_en) begin
      if (!acc_ns)          bp_s  <= clamp_min(wr_data, LO_S);
      else if (!cbp)        bp_ns <= clamp_min(wr_data, LO_NS);
    end
  end

  always_comb begin
    if (!acc_ns)  rd_val = bp_s;
    else if (cbp) rd_val = ns_common_view(bp_s);
    else          rd_val = bp_ns;
  end

  assert_ns_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ns_write_ignored |=> $stable(bp_ns));

  assert_ns_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bp_ns >= LO_NS);

  assert_secure_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_ns) |=> (bp_s >= LO_S && $stable(bp_ns)));

  assert_common_view_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ns && cbp && bp_s == 3'd7) |-> (rd_val == 3'd7));
endmodule

// File: rtl/cif_rpr.sv
module cif_rpr
  import cif_pkg::*;
#(
  parameter bit LEGACY_REV = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rp_load,
  input  logic [7:0] rp_val,
  input  logic       rp_drop,
  output logic [8:0] rp_q,
  output logic [7:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rp_q <= IDLE_PRIO;
    else if (rp_load) rp_q <= {1'b0, rp_val};
    else if (rp_drop) rp_q <= IDLE_PRIO;
  end

  if (LEGACY_REV) begin : g_legacy
    assign rd_val = rp_q[7:0];
  end else begin : g_std
    assign rd_val = (rp_q > 9'h0FF) ? 8'hFF : rp_q[7:0];
  end

  assert_drop_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_drop && !rp_load) |=> (rp_q == IDLE_PRIO));

  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rp_load |=> (rp_q[8] == 1'b0));
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import cif_pkg::*;
#(
  parameter int NUM_IRQ    = 32,
  parameter int NUM_PRIV   = 8,
  parameter int NCPU       = 8,
  parameter int CPU_IDX    = 0,
  parameter bit HAS_GROUPS = 1'b1,
  parameter bit LEGACY_REV = 1'b0,
  parameter int MIN_BP_S   = 0,
  parameter int MIN_BP_NS  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IRQ-1:0]      irq_en,
  input  logic [NUM_IRQ-1:0]      irq_pend,
  input  logic [NUM_IRQ-1:0]      irq_act,
  input  logic [NUM_IRQ-1:0]      irq_grp,
  input  logic [NUM_IRQ*NCPU-1:0] irq_tgt,
  input  logic [NUM_IRQ*8-1:0]    irq_prio,
  input  logic                    ctl_en,
  input  logic                    ctl_cbp,
  input  logic                    rp_load,
  input  logic [7:0]              rp_val,
  input  logic                    rp_drop,
  input  logic                    reg_sel,
  input  logic                    reg_wr,
  input  logic                    reg_ns,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  output logic [ID_W-1:0]         best_id,
  output logic [7:0]              best_prio,
  output logic                    irq_req
);
  logic       best_grp;
  logic [2:0] bp_s, bp_ns, bp_rd, bp_used;
  logic [8:0] rp_q;
  logic [7:0] rp_rd, best_gprio;
  logic       use_alias;

  cif_select #(.NUM_IRQ(NUM_IRQ), .NUM_PRIV(NUM_PRIV), .NCPU(NCPU), .CPU_IDX(CPU_IDX)) u_sel (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_pend(irq_pend), .irq_act(irq_act),
    .irq_grp(irq_grp), .irq_tgt(irq_tgt), .irq_prio(irq_prio),
    .best_id(best_id), .best_prio(best_prio), .best_grp(best_grp));

  cif_bpr #(.MIN_BP_S(MIN_BP_S), .MIN_BP_NS(MIN_BP_NS)) u_bpr (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr & ~reg_sel), .acc_ns(reg_ns),
    .wr_data(reg_wdata[2:0]), .cbp(ctl_cbp), .bp_s(bp_s), .bp_ns(bp_ns), .rd_val(bp_rd));

  cif_rpr #(.LEGACY_REV(LEGACY_REV)) u_rpr (
    .clk(clk), .rst_n(rst_n), .rp_load(rp_load), .rp_val(rp_val), .rp_drop(rp_drop),
    .rp_q(rp_q), .rd_val(rp_rd));

  assign use_alias  = HAS_GROUPS & best_grp & ~ctl_cbp;
  assign bp_used    = use_alias ? ((bp_ns == 3'd0) ? 3'd0 : bp_ns - 3'd1) : bp_s;
  assign best_gprio = grp_prio(best_prio, bp_used);
  assign irq_req    = ctl_en & (best_id != NO_IRQ) & ({1'b0, best_gprio} < rp_q);
  assign reg_rdata  = reg_sel ? rp_rd : {5'd0, bp_rd};

  assert_req_needs_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ctl_en && best_id != NO_IRQ));

  assert_gprio_not_above_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (best_id != NO_IRQ) |-> (best_gprio <= best_prio));

  assert_idle_reads_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEGACY_REV && rp_drop && !rp_load) |=> (!reg_sel || reg_rdata == 8'hFF));
endmodule

// File: tb/test_irq_cpu_if.sv
`timescale 1ns/1ps
module test_irq_cpu_if;
  localparam int N = 16, NP = 4, NC = 4, CI = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_en = '0, irq_pend = '0, irq_act = '0, irq_grp = '0;
  logic [N*NC-1:0] irq_tgt = '0;
  logic [N*8-1:0] irq_prio = '0;
  logic ctl_en = 0, ctl_cbp = 0, rp_load = 0, rp_drop = 0, reg_sel = 0, reg_wr = 0, reg_ns = 0;
  logic [7:0] rp_val = 0, reg_wdata = 0, reg_rdata, best_prio;
  logic [9:0] best_id;
  logic irq_req;

  irq_cpu_if #(.NUM_IRQ(N), .NUM_PRIV(NP), .NCPU(NC), .CPU_IDX(CI)) i_irq_cpu_if (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_pend(irq_pend), .irq_act(irq_act),
    .irq_grp(irq_grp), .irq_tgt(irq_tgt), .irq_prio(irq_prio), .ctl_en(ctl_en),
    .ctl_cbp(ctl_cbp), .rp_load(rp_load), .rp_val(rp_val), .rp_drop(rp_drop),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_ns(reg_ns), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .best_id(best_id), .best_prio(best_prio), .irq_req(irq_req));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_rp = 256, m_bps = 0, m_bpns = 1;

  // reference state, updated on each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (rp_load) m_rp = rp_val;
      else if (rp_drop) m_rp = 256;
      if (reg_wr && !reg_sel) begin
        if (!reg_ns) m_bps = reg_wdata % 8;
        else if (!ctl_cbp) m_bpns = (reg_wdata % 8 < 1) ? 1 : reg_wdata % 8;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int eid = 1023, ep = 255, eg = 0, bp, gp, ereq, erd;
    bit found = 0;
    for (int i = 0; i < N; i++) begin
      int p = irq_prio[i*8 +: 8];
      bit ok = irq_en[i] && irq_pend[i] && !irq_act[i] && (i < NP || irq_tgt[i*NC+CI]);
      if (ok && (!found || p < ep)) begin found = 1; eid = i; ep = p; eg = irq_grp[i]; end
    end
    bp = (eg && !ctl_cbp) ? m_bpns - 1 : m_bps;
    gp = ep - (ep % (1 << (bp + 1)));
    ereq = (ctl_en && found && gp < m_rp) ? 1 : 0;
    if (reg_sel) erd = (m_rp > 255) ? 255 : m_rp;
    else if (!reg_ns) erd = m_bps;
    else if (ctl_cbp) erd = (m_bps + 1 > 7) ? 7 : m_bps + 1;
    else erd = m_bpns;
    chk("R1/R2/R3 best_id", best_id, eid);
    chk("R2/R3 best_prio", best_prio, ep);
    chk("R4/R5 irq_req", irq_req, ereq);
    if (reg_sel) chk("R6/R7 rp read", reg_rdata, erd);
    else if (reg_ns) chk("R8/R9 ns bp read", reg_rdata, erd);
    else chk("R10 s bp read", reg_rdata, erd);
  endtask

  task automatic step();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic set_irq(int i, bit en, bit pd, bit ac, bit gr, int tgt, int p);
    irq_en[i] = en; irq_pend[i] = pd; irq_act[i] = ac; irq_grp[i] = gr;
    irq_tgt[i*NC +: NC] = NC'(tgt); irq_prio[i*8 +: 8] = 8'(p);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(7));
    @(negedge clk); step(); // reset state: R3, R10
    rst_n = 1; @(negedge clk); step();
    ctl_en = 1;
    // R1 single private irq
    set_irq(2, 1, 1, 0, 0, 0, 8'h40); step();
    // R1 active-and-pending never chosen
    irq_act[2] = 1; step();
    irq_act[2] = 0;
    // R1 shared not targeted at this CPU ignored, then targeted taken
    set_irq(9, 1, 1, 0, 0, 4'b0001, 8'h10); step();
    irq_tgt[9*NC+CI] = 1; step();
    // R2 tie: lower ID wins
    set_irq(5, 1, 1, 0, 0, 0, 8'h10); step();
    // R6 load running priority then R5 masking compare
    rp_load = 1; rp_val = 8'h10; step(); rp_load = 0; step();
    // R4 group-1 winner with alias bp-1 = 0: gprio 0x10 -> no request at rp 0x10
    irq_grp[5] = 1; step();
    // R10 secure write 3 -> bp 3, mask low 4 bits
    reg_wr = 1; reg_wdata = 8'hF3; step(); reg_wr = 0; step();
    // R9 non-secure write 0 clamps to 1
    reg_ns = 1; reg_wr = 1; reg_wdata = 8'h00; step(); reg_wr = 0; step();
    // R8/R9 common bit set: write ignored, view saturates
    ctl_cbp = 1; reg_wr = 1; reg_wdata = 8'h06; step(); reg_wr = 0; step();
    reg_ns = 0; reg_wr = 1; reg_wdata = 8'h07; step(); reg_wr = 0; reg_ns = 1; step();
    ctl_cbp = 0; step();
    // R6/R7 drop and load together, then drop alone reads 0xFF
    reg_sel = 1; rp_load = 1; rp_drop = 1; rp_val = 8'h22; step();
    rp_load = 0; step(); rp_drop = 0; step();
    // random traffic
    for (int c = 0; c < 3000; c++) begin
      irq_en   = N'($urandom); irq_pend = N'($urandom | $urandom);
      irq_act  = N'($urandom & $urandom); irq_grp = N'($urandom);
      irq_tgt  = {$urandom, $urandom};
      irq_prio = {$urandom, $urandom, $urandom, $urandom};
      ctl_en = ($urandom % 8) != 0; ctl_cbp = $urandom % 2;
      rp_load = ($urandom % 4) == 0; rp_val = 8'($urandom); rp_drop = ($urandom % 4) == 0;
      reg_sel = $urandom % 2; reg_ns = $urandom % 2;
      reg_wr = ($urandom % 3) == 0; reg_wdata = 8'($urandom);
      step();
    end
    report();
  end
endmodule